// File: doc/BRIEF.md
# Address-Latched One-Hot Line Decoder

This block turns a binary address into one active-high line. The address first passes through a hold stage that a latch-enable input controls. While the latch-enable is low, the address goes straight through to the decoder. The first clock edge that sees the latch-enable high stores the address present at that edge. The stored value then drives the decoder for as long as the latch-enable stays high. This lets a bus owner present an address for a short time, freeze it, and then reuse the address wires while the decoded line stays steady.

Two output enables of opposite polarity sit after the decoder. They act on the outputs no matter what the address or the latch-enable are doing. A parameter builds the top level either as a single 3-to-8 unit or as a two-level cascade. In the cascade, a front unit decodes the upper address bits into the active-high enables of a row of back units. The default build is a 6-line to 64-line decoder with stored address.

Top module: `addr_latch_decoder`

## Requirements
- R1: While `hold_en` is low, the effective address is the live `addr` input. With the outputs enabled, line `addr` is high in the same cycle.
- R2: At the first clock edge that samples `hold_en` high after it was sampled low, or after reset, the `addr` value present at that edge is stored. This holds even if `addr` changed in that same cycle.
- R3: While `hold_en` stays high after the capturing edge, changes on `addr` have no effect on the outputs.
- R4: Every output is low unless `out_en` is 1 and `out_en_n` is 0.
- R5: Switching the output enables off and on while the address is held does not disturb the stored address. When the enables return, the line of the stored address is high again.
- R6: When enabled, exactly one output is high. Its index equals the effective address read as an unsigned binary number, with `addr[ADDR_W-1]` as the most significant bit.
- R7: In the cascade build (`HI_W` > 0), the upper `HI_W` address bits pick which back unit is enabled. The lower `UNIT_W` bits pick the line inside that unit, so output index = effective address across all 2^(UNIT_W+HI_W) lines.
- R8: During reset the stored address is cleared to zero. With the enables inactive, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the hold stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_en | input | 1 | Low: address passes through; high: address frozen |
| addr | input | UNIT_W+HI_W | Binary address, MSB first |
| out_en | input | 1 | Active-high output enable |
| out_en_n | input | 1 | Active-low output enable |
| line | output | 2^(UNIT_W+HI_W) | One-hot decoded outputs |

## Verification
The hardest case to reach is the capturing cycle itself. Here `hold_en` rises in the same cycle that `addr` takes a new value, and the address is then moved around while it is held. The stimulus makes this happen on purpose: it changes both inputs at one falling edge, then walks `addr` through unrelated values over the following cycles. It also pulses the enables off and on before `hold_en` drops again. A long pseudo-random phase adds further cases by mixing short and long hold periods with enable changes. A scoreboard model of the stored address predicts every cycle of that phase.

// File: rtl/addr_latch_decoder_pkg.sv
package addr_latch_decoder_pkg;

   // State of the hold stage as seen at the last clock edge
   typedef enum logic {
      HOLD_PASS = 1'b0,
      HOLD_KEEP = 1'b1
   } hold_state_e;

   // Upper bound on total address width accepted by the library
   localparam int unsigned MAX_ADDR_W = 8;

endpackage

// File: rtl/addr_hold.sv
// Hold stage: a clocked register plus a transparent bypass.
module addr_hold
   import addr_latch_decoder_pkg::*;
#(
   parameter int unsigned AW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hold_en,
   input  logic [AW-1:0] addr_in,
   output logic [AW-1:0] addr_eff
);

   generate
      if (AW < 1) begin : g_bad_aw
         $error("addr_hold: AW must be at least 1");
      end
   endgenerate

   hold_state_e    state_q;
   logic [AW-1:0]  stored_q;
   logic           capture;

   // Capture happens on the edge that first sees hold_en high
   assign capture = hold_en && (state_q == HOLD_PASS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= HOLD_PASS;
         stored_q <= '0;
      end else begin
         state_q <= hold_en ? HOLD_KEEP : HOLD_PASS;
         if (capture) begin
            stored_q <= addr_in;
         end
      end
   end

   // Stored value is used only once a capture has completed
   assign addr_eff = (hold_en && (state_q == HOLD_KEEP)) ? stored_q : addr_in;

endmodule

// File: rtl/onehot_gate.sv
// Binary to one-hot decode with a dual-polarity enable.
module onehot_gate #(
   parameter int unsigned AW = 3,
   localparam int unsigned NL = 1 << AW
) (
   input  logic [AW-1:0] addr,
   input  logic          en,
   input  logic          en_n,
   output logic [NL-1:0] lines
);

   logic active;
   assign active = en && !en_n;

   generate
      for (genvar i = 0; i < NL; i++) begin : g_line
         assign lines[i] = active && (addr == AW'(i));
      end
   endgenerate

endmodule

// File: rtl/dec_unit.sv
// One latched decoder unit: hold stage followed by the gated decode.
module dec_unit #(
   parameter int unsigned AW = 3,
   localparam int unsigned NL = 1 << AW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hold_en,
   input  logic [AW-1:0] addr,
   input  logic          en,
   input  logic          en_n,
   output logic [NL-1:0] lines
);

   logic [AW-1:0] addr_eff;

   addr_hold #(.AW(AW)) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold_en  (hold_en),
      .addr_in  (addr),
      .addr_eff (addr_eff)
   );

   onehot_gate #(.AW(AW)) u_gate (
      .addr  (addr_eff),
      .en    (en),
      .en_n  (en_n),
      .lines (lines)
   );

endmodule

// File: rtl/addr_latch_decoder.sv
// Top level: a single unit, or a front unit driving a row of back units.
module addr_latch_decoder
   import addr_latch_decoder_pkg::*;
#(
   parameter int unsigned UNIT_W = 3,
   parameter int unsigned HI_W   = 3,
   localparam int unsigned ADDR_W = UNIT_W + HI_W,
   localparam int unsigned OUT_W  = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic              out_en,
   input  logic              out_en_n,
   output logic [OUT_W-1:0]  line
);

   localparam int unsigned UNIT_LINES = 1 << UNIT_W;

   generate
      if (UNIT_W < 1) begin : g_bad_unit
         $error("addr_latch_decoder: UNIT_W must be at least 1");
      end
      if (ADDR_W > MAX_ADDR_W) begin : g_bad_total
         $error("addr_latch_decoder: UNIT_W + HI_W exceeds MAX_ADDR_W");
      end

      if (HI_W == 0) begin : g_single
         dec_unit #(.AW(UNIT_W)) u_unit (
            .clk     (clk),
            .rst_n   (rst_n),
            .hold_en (hold_en),
            .addr    (addr),
            .en      (out_en),
            .en_n    (out_en_n),
            .lines   (line)
         );
      end else begin : g_cascade
         localparam int unsigned NUM_UNITS = 1 << HI_W;
         logic [NUM_UNITS-1:0] unit_sel;

         // Front unit decodes the upper bits into per-unit enables
         dec_unit #(.AW(HI_W)) u_front (
            .clk     (clk),
            .rst_n   (rst_n),
            .hold_en (hold_en),
            .addr    (addr[ADDR_W-1:UNIT_W]),
            .en      (out_en),
            .en_n    (out_en_n),
            .lines   (unit_sel)
         );

         for (genvar u = 0; u < NUM_UNITS; u++) begin : g_back
            dec_unit #(.AW(UNIT_W)) u_back (
               .clk     (clk),
               .rst_n   (rst_n),
               .hold_en (hold_en),
               .addr    (addr[UNIT_W-1:0]),
               .en      (unit_sel[u]),
               .en_n    (out_en_n),
               .lines   (line[u*UNIT_LINES +: UNIT_LINES])
            );
         end
      end
   endgenerate

endmodule

// File: rtl/addr_latch_decoder_chk.sv
module addr_latch_decoder_chk #(
   parameter int unsigned UNIT_W = 3,
   parameter int unsigned HI_W   = 3,
   localparam int unsigned ADDR_W = UNIT_W + HI_W,
   localparam int unsigned OUT_W  = 1 << ADDR_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hold_en,
   input logic [ADDR_W-1:0] addr,
   input logic              out_en,
   input logic              out_en_n,
   input logic [OUT_W-1:0]  line
);

   logic act;
   logic armed_q;
   assign act = out_en && !out_en_n;

   // Set once one edge out of reset has passed, so $past is meaningful
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed_q <= 1'b0;
      else        armed_q <= 1'b1;
   end

   // R4: no line while the enables are not both asserted
   a_r4_gated_off: assert property (@(posedge clk) disable iff (!rst_n)
      !act |-> (line == '0));

   // R6: never more than one line
   a_r6_at_most_one: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(line));

   // R6: exactly one line when enabled
   a_r6_one_when_on: assert property (@(posedge clk) disable iff (!rst_n)
      act |-> ($countones(line) == 1));

   // R1, R7: transparent path selects the live address
   a_r1_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_en && act) |-> line[addr]);

   // R3: held address keeps outputs steady
   a_r3_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && hold_en && $past(hold_en) && act && $past(act)) |-> $stable(line));

endmodule

bind addr_latch_decoder addr_latch_decoder_chk #(.UNIT_W(UNIT_W), .HI_W(HI_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .hold_en  (hold_en),
   .addr     (addr),
   .out_en   (out_en),
   .out_en_n (out_en_n),
   .line     (line)
);

// File: tb/addr_latch_decoder_test.sv
`timescale 1ns/1ps
module addr_latch_decoder_test;

   localparam int unsigned UNIT_W = 3;
   localparam int unsigned HI_W   = 3;
   localparam int unsigned ADDR_W = UNIT_W + HI_W;
   localparam int unsigned OUT_W  = 1 << ADDR_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              hold_en = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic              out_en = 1'b0;
   logic              out_en_n = 1'b1;
   logic [OUT_W-1:0]  line;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // Reference model state
   logic              m_keep = 1'b0;
   logic [ADDR_W-1:0] m_stored = '0;

   logic [OUT_W-1:0]  exp_q [$];
   string             tag_q [$];
   event              sample_ev;

   always #5 clk = ~clk;

   addr_latch_decoder #(.UNIT_W(UNIT_W), .HI_W(HI_W)) uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold_en  (hold_en),
      .addr     (addr),
      .out_en   (out_en),
      .out_en_n (out_en_n),
      .line     (line)
   );

   // Model of the hold stage, updated on the same edges as the design
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_keep   <= 1'b0;
         m_stored <= '0;
      end else begin
         if (hold_en && !m_keep) m_stored <= addr;
         m_keep <= hold_en;
      end
   end

   function automatic logic [OUT_W-1:0] predict();
      logic [ADDR_W-1:0] eff;
      logic [OUT_W-1:0] v;
      eff = (hold_en && m_keep) ? m_stored : addr;
      v = '0;
      if (out_en && !out_en_n) v[eff] = 1'b1;
      return v;
   endfunction

   // Driver: apply inputs after a falling edge and queue the prediction
   task automatic drive(input logic he, input logic [ADDR_W-1:0] a,
                        input logic e, input logic en_n, input string tag);
      @(negedge clk);
      hold_en  = he;
      addr     = a;
      out_en   = e;
      out_en_n = en_n;
      #1;
      exp_q.push_back(predict());
      tag_q.push_back(tag);
      -> sample_ev;
   endtask

   // Monitor: compare the outputs against the queued prediction
   initial begin
      forever begin
         @(sample_ev);
         #1;
         while (exp_q.size() > 0) begin
            logic [OUT_W-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (line !== e) begin
               errors++;
               $display("FAIL %s: line=%h expected=%h", t, line, e);
            end
         end
      end
   end

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [ADDR_W-1:0] held;
      logic [31:0] lfsr;

      // R8: reset with enables off gives all-zero outputs
      drive(1'b0, 6'd9, 1'b0, 1'b1, "R8 reset");
      drive(1'b1, 6'd41, 1'b0, 1'b1, "R8 reset");
      @(negedge clk);
      rst_n = 1'b1;
      drive(1'b0, 6'd0, 1'b0, 1'b1, "R8 after reset");

      // R1 / R6 / R7: transparent sweep across every line
      for (int i = 0; i < OUT_W; i++)
         drive(1'b0, ADDR_W'(i), 1'b1, 1'b0, "R1 R6 R7 sweep");

      // R4: each inactive enable combination blanks the outputs
      drive(1'b0, 6'd17, 1'b0, 1'b0, "R4 en low");
      drive(1'b0, 6'd17, 1'b1, 1'b1, "R4 en_n high");
      drive(1'b0, 6'd63, 1'b0, 1'b1, "R4 both off");

      // R2 / R3: capture 37, then move addr while held
      drive(1'b0, 6'd37, 1'b1, 1'b0, "R1 before hold");
      drive(1'b1, 6'd37, 1'b1, 1'b0, "R2 capture");
      drive(1'b1, 6'd2,  1'b1, 1'b0, "R3 held");
      drive(1'b1, 6'd60, 1'b1, 1'b0, "R3 held");
      drive(1'b1, 6'd0,  1'b1, 1'b0, "R3 held");

      // R5: enables off and on while held
      drive(1'b1, 6'd11, 1'b0, 1'b1, "R5 off while held");
      drive(1'b1, 6'd12, 1'b1, 1'b1, "R5 off while held");
      drive(1'b1, 6'd13, 1'b1, 1'b0, "R5 back on");

      // R1: release returns to the live address
      drive(1'b0, 6'd5, 1'b1, 1'b0, "R1 release");

      // R2: addr changes in the same cycle as hold_en rises
      drive(1'b1, 6'd50, 1'b1, 1'b0, "R2 same-cycle capture");
      drive(1'b1, 6'd5,  1'b1, 1'b0, "R2 held 50");
      drive(1'b1, 6'd7,  1'b1, 1'b0, "R3 held 50");

      // R2: capture while enables are off, reveal later
      drive(1'b0, 6'd8,  1'b0, 1'b1, "R4 off");
      drive(1'b1, 6'd58, 1'b0, 1'b1, "R2 capture hidden");
      drive(1'b1, 6'd1,  1'b0, 1'b1, "R3 hidden");
      drive(1'b1, 6'd3,  1'b1, 1'b0, "R2 reveal 58");
      drive(1'b0, 6'd3,  1'b1, 1'b0, "R1 release");

      // Pseudo-random phase mixing holds and enable changes
      lfsr = 32'hACE1_1234;
      for (int n = 0; n < 400; n++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         held = lfsr[ADDR_W-1:0];
         drive(lfsr[8] | lfsr[9], held, lfsr[12] | lfsr[13] | lfsr[14], lfsr[15] & lfsr[16],
               "R2 R3 R4 R5 R6 random");
      end

      @(negedge clk);
      #3;
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule